// File: doc/BRIEF.md
# Multi-transform multiply-accumulate cell

This block is one processing element of a systolic transform array. In each cycle it scales an input sample by a transform coefficient and adds the result to a partial sum handed over by a neighbouring cell. A chain of such cells, with each cell given its own `(n, k)` indices, builds up one output bin of a length-N transform. The cell serves five kinds of work: the discrete Fourier transform (DFT), the discrete cosine transform (DCT), the discrete sine transform (DST), the discrete Hartley transform (DHT), and a sum of absolute differences (SAD). The datapath is the same for all five. Only the coefficients drawn from the built-in table and the way the two products are combined change.

The coefficient table is computed at elaboration from `N_PT`. It holds two signed Q1.15 terms per cell. The first term is addressed by `(n, k1)` and the second by `(n, k2)`. Two rounding multipliers scale the sample by these terms. A combine stage then adds the products, keeps them apart, or takes the absolute value of their difference. Saturating adders fold the combined terms into the incoming real and imaginary partial sums. The results are registered once before they leave the cell.

Top module: `xform_mac_cell`

## Requirements
- R1: A synchronous active-low reset clears both partial-sum outputs to zero. The reset overrides any input applied at the same time.
- R2: Each result is registered. Outputs change only on a rising clock edge and reflect the inputs sampled at that edge.
- R3: The mode select is a 3-bit field: DFT=0, DCT=1, DST=2, DHT=3, SAD=4. Every coefficient is a signed Q1.15 value, with +1.0 stored as 32767. Each product is computed as (sample·coef + 16384) >>> 15. With DFT=0, the real output is `psum_re_in + P(x, cos(2πn·k1/N))` and the imaginary output is `psum_im_in + P(x, −sin(2πn·k2/N))`.
- R4: With DCT=1, the real output adds `P(x, a·cos(π(2n+1)k1/(2N)))`, where a = 1/√N for k1=0 and √(2/N) otherwise. `idx_k2` has no effect.
- R5: With DST=2, the real output adds `P(x, sin(π(n+1)(k1+1)/(N+1)))`. `idx_k2` has no effect.
- R6: With DHT=3, the real output adds `P(x, cos(2πn·k1/N)) + P(x, sin(2πn·k2/N))`. The same sample feeds both multipliers.
- R7: With SAD=4, no coefficient is applied. The real output adds |sample_a − sample_b|.
- R8: In every mode other than DFT, `psum_im_out` equals `psum_im_in` from the previous edge.
- R9: Each sum saturates at +2^(ACC_W−1)−1 and −2^(ACC_W−1) and never wraps.
- R10: `sample_b` has no effect outside SAD.
- R11: Mode codes 5, 6 and 7 add nothing. Both partial sums pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 3 | Operation select (encoding in R3) |
| idx_n | input | IDX_W (3) | Sample index n |
| idx_k1 | input | IDX_W (3) | Bin index for the first coefficient term |
| idx_k2 | input | IDX_W (3) | Bin index for the second coefficient term |
| sample_a | input | DATA_W (16) | Signed sample x(n) |
| sample_b | input | DATA_W (16) | Signed second operand y(n), SAD only |
| psum_re_in | input | ACC_W (24) | Signed real partial sum from the upstream cell |
| psum_im_in | input | ACC_W (24) | Signed imaginary partial sum from the upstream cell |
| psum_re_out | output | ACC_W (24) | Registered signed real partial sum |
| psum_im_out | output | ACC_W (24) | Registered signed imaginary partial sum |

## Verification
Every result is due exactly one rising edge after its inputs are presented. The bench changes inputs on the falling edge and compares both sums at the next falling edge, so only one register stage separates stimulus and check. A separate check changes the inputs just after a rising edge and confirms that the outputs keep the previous result until the following edge. The bench sweeps every (n, k1) pair in each transform mode, and the expected coefficients come from real-valued trigonometry. Products are therefore allowed one LSB of coefficient rounding difference per multiplier, while SAD, pass-through and saturation results must match exactly.

// File: rtl/xfm_cell_pkg.sv
// Package: shared mode encoding and elaboration-time fixed-point trigonometry
// for the multi-transform cell. The functions are only evaluated as constants
// while the coefficient table is built; they produce no hardware of their own.
package xfm_cell_pkg;

    typedef enum logic [2:0] {
        XM_DFT = 3'd0,
        XM_DCT = 3'd1,
        XM_DST = 3'd2,
        XM_DHT = 3'd3,
        XM_SAD = 3'd4
    } xform_mode_e;

    localparam longint ONE_Q30      = 64'sd1 <<< 30;
    localparam longint QUARTER_TURN = 64'sd1 <<< 30;
    localparam longint FULL_TURN    = 64'sd1 <<< 32;
    localparam longint HALF_PI_Q30  = 64'sd1686629713;

    // Cosine of a phase given in 2^-32 turns, result in Q30 (Taylor series per quadrant).
    function automatic longint cos_q30(input longint turns);
        longint t, quad, frac, phi, x2;
        longint term_c, term_s, c_acc, s_acc;
        t      = turns & 64'h0000_0000_FFFF_FFFF;
        quad   = t >>> 30;
        frac   = t & 64'h0000_0000_3FFF_FFFF;
        phi    = (frac * HALF_PI_Q30) >>> 30;
        x2     = (phi * phi) >>> 30;
        c_acc  = ONE_Q30;
        term_c = ONE_Q30;
        s_acc  = phi;
        term_s = phi;
        for (int i = 1; i <= 8; i++) begin
            term_c = -((term_c * x2) >>> 30) / longint'((2 * i - 1) * (2 * i));
            term_s = -((term_s * x2) >>> 30) / longint'((2 * i) * (2 * i + 1));
            c_acc  = c_acc + term_c;
            s_acc  = s_acc + term_s;
        end
        if (quad == 0)      return c_acc;
        else if (quad == 1) return -s_acc;
        else if (quad == 2) return -c_acc;
        else                return s_acc;
    endfunction

    // Phase num/den of a full turn expressed in 2^-32 turns.
    function automatic longint turns_of(input longint num, input longint den);
        return ((num % den) * FULL_TURN) / den;
    endfunction

    // Integer square root of a non-negative value below 2^62.
    function automatic longint isqrt64(input longint v);
        longint r, cand;
        r = 0;
        for (int b = 30; b >= 0; b--) begin
            cand = r | (64'sd1 <<< b);
            if (cand * cand <= v) r = cand;
        end
        return r;
    endfunction

    // DCT normalisation gain in Q30: 1/sqrt(N) for bin 0, sqrt(2/N) otherwise.
    function automatic longint dct_gain_q30(input int k, input int n_pt);
        if (k == 0) return isqrt64((64'sd1 <<< 60) / longint'(n_pt));
        else        return isqrt64((64'sd1 <<< 61) / longint'(n_pt));
    endfunction

    // amp*cos(phase) rounded to a signed fraction with frac bits, clamped to range.
    function automatic int coef_fix(input longint turns, input longint amp_q30, input int frac);
        longint wide, r, lim;
        int     sh;
        sh   = 60 - frac;
        wide = cos_q30(turns) * amp_q30;
        r    = (wide + (64'sd1 <<< (sh - 1))) >>> sh;
        lim  = (64'sd1 <<< frac) - 1;
        if (r > lim)        r = lim;
        if (r < -(lim + 1)) r = -(lim + 1);
        return int'(r);
    endfunction

endpackage

// File: rtl/xfm_coef_rom.sv
// Coefficient table: supplies the two signed fixed-point coefficient terms for
// the selected mode and index pairs (n,k1) and (n,k2).
// Assumes N_PT is a power of two so that {n,k} addresses an N_PT*N_PT table.
// All entries are constants computed at elaboration; the read is combinational.
module xfm_coef_rom
    import xfm_cell_pkg::*;
#(
    parameter int N_PT   = 8,
    parameter int COEF_W = 16,
    localparam int IDX_W = $clog2(N_PT)
) (
    input  logic [2:0]                mode,
    input  logic [IDX_W-1:0]          idx_n,
    input  logic [IDX_W-1:0]          idx_k1,
    input  logic [IDX_W-1:0]          idx_k2,
    output logic signed [COEF_W-1:0]  coef1,
    output logic signed [COEF_W-1:0]  coef2
);
    localparam int TAB  = N_PT * N_PT;
    localparam int FRAC = COEF_W - 1;

    logic signed [COEF_W-1:0] t_cos  [TAB];
    logic signed [COEF_W-1:0] t_nsin [TAB];
    logic signed [COEF_W-1:0] t_sin  [TAB];
    logic signed [COEF_W-1:0] t_dct  [TAB];
    logic signed [COEF_W-1:0] t_dst  [TAB];

    // One table row per (n,k): every transform's entry derived from its phase.
    for (genvar g = 0; g < TAB; g++) begin : g_entry
        localparam int     RN = g / N_PT;
        localparam int     RK = g % N_PT;
        localparam longint PH = turns_of(longint'(RN * RK), longint'(N_PT));
        localparam longint PC = turns_of(longint'((2 * RN + 1) * RK), longint'(4 * N_PT));
        localparam longint PS = turns_of(longint'((RN + 1) * (RK + 1)), longint'(2 * (N_PT + 1)));
        assign t_cos[g]  = COEF_W'(coef_fix(PH, ONE_Q30, FRAC));
        assign t_nsin[g] = COEF_W'(coef_fix(QUARTER_TURN + PH, ONE_Q30, FRAC));
        assign t_sin[g]  = COEF_W'(coef_fix(QUARTER_TURN - PH, ONE_Q30, FRAC));
        assign t_dct[g]  = COEF_W'(coef_fix(PC, dct_gain_q30(RK, N_PT), FRAC));
        assign t_dst[g]  = COEF_W'(coef_fix(QUARTER_TURN - PS, ONE_Q30, FRAC));
    end

    logic [2*IDX_W-1:0] addr1, addr2;
    assign addr1 = {idx_n, idx_k1};
    assign addr2 = {idx_n, idx_k2};

    // Mode-driven selection of the two coefficient terms.
    always_comb begin
        coef1 = '0;
        coef2 = '0;
        case (mode)
            XM_DFT: begin coef1 = t_cos[addr1]; coef2 = t_nsin[addr2]; end
            XM_DCT: coef1 = t_dct[addr1];
            XM_DST: coef1 = t_dst[addr1];
            XM_DHT: begin coef1 = t_cos[addr1]; coef2 = t_sin[addr2]; end
            default: ;
        endcase
    end
endmodule

// File: rtl/xfm_scale.sv
// Rounding multiplier: operand times a signed fraction with COEF_W-1 fraction
// bits, rounded half up. When 'unity' is set the operand passes at unit gain.
// Assumes |operand*coef| stays below 2^(DATA_W+COEF_W-1) (always true for Q1.15).
module xfm_scale #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16
) (
    input  logic signed [DATA_W-1:0] operand,
    input  logic signed [COEF_W-1:0] coef,
    input  logic                     unity,
    output logic signed [DATA_W:0]   prod
);
    localparam int FRAC   = COEF_W - 1;
    localparam int FULL_W = DATA_W + COEF_W;
    localparam logic signed [FULL_W-1:0] HALF = FULL_W'(1) << (FRAC - 1);

    logic signed [FULL_W-1:0] full;

    // Full-precision signed product.
    assign full = FULL_W'(operand) * FULL_W'(coef);

    // Rounded scale or unit-gain bypass.
    assign prod = unity ? {operand[DATA_W-1], operand}
                        : (DATA_W + 1)'((full + HALF) >>> FRAC);
endmodule

// File: rtl/xfm_sat_add.sv
// Saturating adder: folds a signed term into a signed partial sum and clamps
// the result to the ACC_W range instead of wrapping. Assumes TERM_W <= ACC_W.
module xfm_sat_add #(
    parameter int ACC_W  = 24,
    parameter int TERM_W = 18
) (
    input  logic signed [ACC_W-1:0]  acc_in,
    input  logic signed [TERM_W-1:0] term,
    output logic signed [ACC_W-1:0]  sum_out
);
    localparam logic signed [ACC_W:0] HI = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] LO = {2'b11, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W:0] wide;

    // One extra bit of headroom for the raw sum.
    assign wide = {acc_in[ACC_W-1], acc_in} + {{(ACC_W+1-TERM_W){term[TERM_W-1]}}, term};

    // Clamp to the representable range.
    always_comb begin
        if (wide > HI)      sum_out = HI[ACC_W-1:0];
        else if (wide < LO) sum_out = LO[ACC_W-1:0];
        else                sum_out = wide[ACC_W-1:0];
    end
endmodule

// File: rtl/xform_mac_cell.sv
// Multi-transform multiply-accumulate cell: one systolic processing element.
// Looks up two coefficient terms, scales the sample(s), combines the products
// per mode, adds them to the neighbour's partial sums with saturation and
// registers the result (one clock of latency).
// Assumes N_PT is a power of two and DATA_W + 2 <= ACC_W.
module xform_mac_cell
    import xfm_cell_pkg::*;
#(
    parameter int N_PT   = 8,
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 24,
    localparam int IDX_W = $clog2(N_PT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               mode,
    input  logic [IDX_W-1:0]         idx_n,
    input  logic [IDX_W-1:0]         idx_k1,
    input  logic [IDX_W-1:0]         idx_k2,
    input  logic signed [DATA_W-1:0] sample_a,
    input  logic signed [DATA_W-1:0] sample_b,
    input  logic signed [ACC_W-1:0]  psum_re_in,
    input  logic signed [ACC_W-1:0]  psum_im_in,
    output logic signed [ACC_W-1:0]  psum_re_out,
    output logic signed [ACC_W-1:0]  psum_im_out
);
    localparam int PROD_W = DATA_W + 1;
    localparam int TERM_W = DATA_W + 2;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

    logic signed [COEF_W-1:0] coef1, coef2;
    logic signed [PROD_W-1:0] prod1, prod2;
    logic signed [DATA_W-1:0] op2;
    logic                     is_sad;
    logic signed [TERM_W-1:0] ext1, ext2, diff, term_re, term_im;
    logic signed [ACC_W-1:0]  sum_re, sum_im;

    xfm_coef_rom #(.N_PT(N_PT), .COEF_W(COEF_W)) u_rom (
        .mode   (mode),
        .idx_n  (idx_n),
        .idx_k1 (idx_k1),
        .idx_k2 (idx_k2),
        .coef1  (coef1),
        .coef2  (coef2)
    );

    // SAD bypasses the coefficients and routes the second operand to multiplier 2.
    assign is_sad = (mode == XM_SAD);
    assign op2    = is_sad ? sample_b : sample_a;

    xfm_scale #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul1 (
        .operand (sample_a),
        .coef    (coef1),
        .unity   (is_sad),
        .prod    (prod1)
    );

    xfm_scale #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul2 (
        .operand (op2),
        .coef    (coef2),
        .unity   (is_sad),
        .prod    (prod2)
    );

    // Combine the two products into the real and imaginary terms per mode.
    always_comb begin
        ext1    = {prod1[PROD_W-1], prod1};
        ext2    = {prod2[PROD_W-1], prod2};
        diff    = ext1 - ext2;
        term_re = '0;
        term_im = '0;
        case (mode)
            XM_DFT: begin term_re = ext1; term_im = ext2; end
            XM_DCT, XM_DST, XM_DHT: term_re = ext1 + ext2;
            XM_SAD: term_re = diff[TERM_W-1] ? -diff : diff;
            default: ;
        endcase
    end

    xfm_sat_add #(.ACC_W(ACC_W), .TERM_W(TERM_W)) u_add_re (
        .acc_in  (psum_re_in),
        .term    (term_re),
        .sum_out (sum_re)
    );

    xfm_sat_add #(.ACC_W(ACC_W), .TERM_W(TERM_W)) u_add_im (
        .acc_in  (psum_im_in),
        .term    (term_im),
        .sum_out (sum_im)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psum_re_out <= '0;
            psum_im_out <= '0;
        end else begin
            psum_re_out <= sum_re;
            psum_im_out <= sum_im;
        end
    end

    // R1: the first cycle out of reset shows cleared sums.
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (psum_re_out == '0 && psum_im_out == '0));

    // R3: a zero sample contributes nothing to the real sum in transform modes.
    assert_zero_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sample_a) == '0 && $past(mode) <= 3'd3)
        |-> psum_re_out == $past(psum_re_in));

    // R7: an absolute difference never lowers the real sum.
    assert_sad_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == XM_SAD) |-> psum_re_out >= $past(psum_re_in));

    // R8: the imaginary chain is untouched outside DFT.
    assert_im_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) != XM_DFT) |-> psum_im_out == $past(psum_im_in));

    // R9: a full-scale sum stays at full scale under SAD instead of wrapping.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == XM_SAD && $past(psum_re_in) == ACC_MAX)
        |-> psum_re_out == ACC_MAX);

    // R11: reserved codes leave the real chain untouched.
    assert_reserved_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) > 3'd4) |-> psum_re_out == $past(psum_re_in));
endmodule

// File: tb/xform_mac_cell_tb_top.sv
// Self-checking bench: sweeps every (n,k) pair in each transform mode, a grid
// of SAD operands, saturation corners, reserved codes, reset and latency.
module xform_mac_cell_tb_top;
    localparam int     CLK_PERIOD = 10;
    localparam int     N_PT       = 8;
    localparam int     DATA_W     = 16;
    localparam int     ACC_W      = 24;
    localparam int     IDX_W      = 3;
    localparam longint AMAX       = (64'sd1 <<< (ACC_W - 1)) - 1;
    localparam longint AMIN       = -(64'sd1 <<< (ACC_W - 1));
    localparam real    PI         = 3.14159265358979323846;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [2:0]               mode = 3'd4;
    logic [IDX_W-1:0]         idx_n = '0, idx_k1 = '0, idx_k2 = '0;
    logic signed [DATA_W-1:0] sample_a = 16'sd1000, sample_b = 16'sd0;
    logic signed [ACC_W-1:0]  psum_re_in = 24'sd77, psum_im_in = 24'sd55;
    logic signed [ACC_W-1:0]  psum_re_out, psum_im_out;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xform_mac_cell #(.N_PT(N_PT), .DATA_W(DATA_W), .COEF_W(16), .ACC_W(ACC_W)) dut_i (
        .clk, .rst_n, .mode, .idx_n, .idx_k1, .idx_k2,
        .sample_a, .sample_b, .psum_re_in, .psum_im_in,
        .psum_re_out, .psum_im_out
    );

    function automatic longint qc(input real v);
        longint q;
        q = longint'(v * 32768.0);
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    function automatic longint rp(input longint x, input longint c);
        return (x * c + 16384) >>> 15;
    endfunction

    function automatic longint sat(input longint v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    task automatic chk(input string req, input string what, input longint act,
                       input longint exp, input longint tol);
        checks++;
        if (act - exp > tol || exp - act > tol) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one vector on the falling edge, check both sums at the next falling edge.
    task automatic vec(input logic [2:0] m, input int n, input int k1, input int k2,
                       input int xa, input int xb, input longint re, input longint im,
                       input string req);
        longint er, ei, tr, ti;
        real    al;
        er = re; ei = im; tr = 0; ti = 0;
        case (m)
            3'd0: begin
                er = sat(re + rp(xa, qc($cos(2.0 * PI * real'(n * k1) / real'(N_PT)))));
                ei = sat(im + rp(xa, qc(-$sin(2.0 * PI * real'(n * k2) / real'(N_PT)))));
                tr = 1; ti = 1;
            end
            3'd1: begin
                al = (k1 == 0) ? 1.0 / $sqrt(real'(N_PT)) : $sqrt(2.0 / real'(N_PT));
                er = sat(re + rp(xa, qc(al * $cos(PI * real'((2 * n + 1) * k1) / real'(2 * N_PT)))));
                tr = 1;
            end
            3'd2: begin
                er = sat(re + rp(xa, qc($sin(PI * real'((n + 1) * (k1 + 1)) / real'(N_PT + 1)))));
                tr = 1;
            end
            3'd3: begin
                er = sat(re + rp(xa, qc($cos(2.0 * PI * real'(n * k1) / real'(N_PT))))
                            + rp(xa, qc($sin(2.0 * PI * real'(n * k2) / real'(N_PT)))));
                tr = 2;
            end
            3'd4: er = sat(re + ((xa > xb) ? longint'(xa - xb) : longint'(xb - xa)));
            default: ;
        endcase
        mode = m; idx_n = IDX_W'(n); idx_k1 = IDX_W'(k1); idx_k2 = IDX_W'(k2);
        sample_a = DATA_W'(xa); sample_b = DATA_W'(xb);
        psum_re_in = ACC_W'(re); psum_im_in = ACC_W'(im);
        @(negedge clk);
        chk(req, "re", longint'(psum_re_out), er, tr);
        chk(req, "im", longint'(psum_im_out), ei, ti);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int xs [3];
        int grid [9];
        xs   = '{12345, -20000, 32767};
        grid = '{-32768, -20000, -1, 0, 1, 777, 15000, 30000, 32767};

        // R1: reset dominates non-zero inputs.
        repeat (3) @(negedge clk);
        chk("R1", "re", longint'(psum_re_out), 0, 0);
        chk("R1", "im", longint'(psum_im_out), 0, 0);
        rst_n = 1'b1;

        // R3 R4 R5 R6: every (n,k1) pair, varied k2, three sample values, b not zero (R10).
        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n < N_PT; n++) begin
                for (int k = 0; k < N_PT; k++) begin
                    for (int s = 0; s < 3; s++) begin
                        vec(3'(m), n, k, (k * 3 + n + s) % N_PT, xs[s], 9000 - 1000 * s,
                            longint'(1000 * n - 5000), longint'(-777 * k),
                            (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6");
                    end
                end
            end
        end

        // R7: SAD over a grid of operand pairs.
        for (int i = 0; i < 9; i++) begin
            for (int j = 0; j < 9; j++) begin
                vec(3'd4, i % N_PT, j % N_PT, 0, grid[i], grid[j], longint'(i * 1000 - j * 300), 4242, "R7");
            end
        end

        // R8: imaginary sum passes through in DCT, DST, DHT and SAD.
        vec(3'd1, 3, 2, 5, 20000, 0, 10, -123456, "R8");
        vec(3'd3, 5, 1, 1, -15000, 0, 10, 654321, "R8");

        // R9: saturation at both ends on both chains.
        vec(3'd4, 0, 0, 0, 32767, -32768, AMAX - 5, 0, "R9");
        vec(3'd0, 0, 0, 1, -32768, 0, AMIN + 10, 0, "R9");
        vec(3'd0, 1, 0, 2, 32767, 0, 0, AMIN + 3, "R9");
        vec(3'd3, 1, 1, 1, 32767, 0, AMAX - 1, 0, "R9");

        // R10: DCT result unchanged while sample_b changes.
        vec(3'd1, 2, 3, 0, 25000, -32768, 500, 0, "R10");
        vec(3'd1, 2, 3, 0, 25000, 32767, 500, 0, "R10");

        // R11: reserved codes are pass-through.
        vec(3'd5, 1, 1, 1, 30000, 100, 31415, -2718, "R11");
        vec(3'd6, 2, 2, 2, -30000, 100, -31415, 2718, "R11");
        vec(3'd7, 3, 3, 3, 12345, -9, 1, -1, "R11");

        // R2: result appears at the edge and holds until the next one.
        mode = 3'd4; sample_a = 16'sd500; sample_b = 16'sd200;
        psum_re_in = 24'sd0; psum_im_in = 24'sd0;
        @(posedge clk);
        #1;
        mode = 3'd4; sample_a = 16'sd0; sample_b = 16'sd9000; psum_re_in = 24'sd5;
        chk("R2", "re after edge", longint'(psum_re_out), 300, 0);
        @(negedge clk);
        chk("R2", "re held", longint'(psum_re_out), 300, 0);
        @(negedge clk);
        chk("R2", "re next", longint'(psum_re_out), 9005, 0);

        // R1: reset in mid-run clears the sums.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "re mid-run", longint'(psum_re_out), 0, 0);
        chk("R1", "im mid-run", longint'(psum_im_out), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        report();
    end
endmodule